// File: doc/BRIEF.md
# Sign-Extending Load Unit

This unit executes the load instructions of a packet-filter style virtual machine. It takes one 64-bit instruction word and decodes the class, size, mode, register and offset fields. It reads the base register through an external register-file read port and adds the sign-extended 16-bit displacement to form the effective address. It then issues exactly one read request on a valid/ready memory port.

When the read response arrives, the unit trims the returned little-endian bytes to the access width. It widens them to 64 bits by zero fill or by replicating the top loaded bit, and writes the result to the destination register through an external write port. Any word that is not a supported load is reported on a one-cycle illegal flag, with no memory traffic and no register write.

Top module: `load_sext_unit`

## Requirements
- R1: After reset, instReady is 1 and memReqValid, rfWrEn and illegalInst are 0.
- R2: Fields are taken from the instruction word as follows. Opcode byte bits 2:0 hold the class, bits 4:3 the size and bits 7:5 the mode. Byte 1 bits 3:0 hold the destination register and bits 7:4 the source register. While the unit is idle, rfRdAddr equals the source field.
- R3: In the cycle after a legal load is accepted, memReqValid is 1. memReqAddr equals the source register value plus the sign-extended 16-bit displacement held little-endian in bytes 2 and 3. Both signals hold steady until memReqReady is seen.
- R4: memReqSize carries the size field unchanged. Its encoding is 0 = 4 bytes, 1 = 2 bytes, 2 = 1 byte and 3 = 8 bytes.
- R5: A load with class 1 and mode 3 writes the low access-width bytes of memRspData with zeros above them. Size 3 writes all 64 bits.
- R6: A load with class 1 and mode 4 and size 0, 1 or 2 writes the low access-width bytes, with every bit above them equal to the most significant loaded bit.
- R7: rfWrEn is asserted for exactly one cycle per legal load, only in a cycle where memRspValid is 1 and the request has been or is being accepted. rfWrAddr equals the destination field in that cycle.
- R8: The unit raises illegalInst for one cycle, the cycle after acceptance, and issues no memory request and no register write in the following cases: the class is not 1, the mode is neither 3 nor 4, or the mode is 4 with size 3.
- R9: A response that is valid in the same cycle as memReqReady completes the load in that cycle, with rfWrEn asserted.
- R10: From acceptance of a legal load until its register write, instReady is 0. Instruction words presented during that time are ignored and cause neither an illegal flag nor an extra write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| instValid | input | 1 | Instruction word is presented |
| instWord | input | 64 | Instruction word |
| instReady | output | 1 | Unit is idle and accepts an instruction |
| illegalInst | output | 1 | One-cycle pulse for an unsupported instruction |
| rfRdAddr | output | 4 | Register-file read address (base register) |
| rfRdData | input | 64 | Register-file read data, combinational |
| memReqValid | output | 1 | Read request valid |
| memReqReady | input | 1 | Memory accepts the request |
| memReqAddr | output | 64 | Effective byte address |
| memReqSize | output | 2 | Access size code |
| memRspValid | input | 1 | Read data valid |
| memRspData | input | 64 | Read data, little-endian in the low bytes |
| rfWrEn | output | 1 | Destination register write strobe |
| rfWrAddr | output | 4 | Destination register index |
| rfWrData | output | 64 | Extended load result |

## Verification
The request handshake and the response can land in the same cycle. In that case the unit must skip its waiting state and write the register in that very cycle. The bench provokes this by raising memReqReady and memRspValid together in one cycle, and also by spreading them over several cycles with stalls on each side. In every case it judges that exactly one write appears, in the cycle the response is valid, with the expected extended value and destination.

// File: rtl/lsu_pkg.sv
package lsu_pkg;
  localparam logic [2:0] CLS_LOAD = 3'd1;
  localparam logic [2:0] MODE_ZEXT = 3'd3;
  localparam logic [2:0] MODE_SEXT = 3'd4;
  localparam logic [1:0] SZ_DWORD = 2'd3;

  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_WAIT} lsuStateE;

  typedef struct packed {
    logic capture;
    logic illegalSet;
    logic writeBack;
  } lsuStrobeT;

  function automatic logic [3:0] sizeToBytes(input logic [1:0] sz);
    case (sz)
      2'd0: return 4'd4;
      2'd1: return 4'd2;
      2'd2: return 4'd1;
      default: return 4'd8;
    endcase
  endfunction
endpackage

// File: rtl/lsu_ctrl.sv
module lsu_ctrl
  import lsu_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      instValid,
  input  logic      legal,
  input  logic      memReqReady,
  input  logic      memRspValid,
  output logic      instReady,
  output logic      memReqValid,
  output logic      illegalInst,
  output lsuStrobeT strobe
);
  lsuStateE stateQ, stateD;

  always_comb begin
    stateD = stateQ;
    strobe = '0;
    instReady = 1'b0;
    memReqValid = 1'b0;
    case (stateQ)
      ST_IDLE: begin
        instReady = 1'b1;
        if (instValid) begin
          strobe.capture = legal;
          strobe.illegalSet = !legal;
          stateD = legal ? ST_REQ : ST_IDLE;
        end
      end
      ST_REQ: begin
        memReqValid = 1'b1;
        if (memReqReady) begin
          if (memRspValid) begin
            strobe.writeBack = 1'b1;
            stateD = ST_IDLE;
          end else begin
            stateD = ST_WAIT;
          end
        end
      end
      ST_WAIT: begin
        if (memRspValid) begin
          strobe.writeBack = 1'b1;
          stateD = ST_IDLE;
        end
      end
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      illegalInst <= 1'b0;
    end else begin
      stateQ <= stateD;
      illegalInst <= strobe.illegalSet;
    end
  end
endmodule

// File: rtl/lsu_dpath.sv
module lsu_dpath
  import lsu_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int REG_AW = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [31:0]       instLow,
  input  logic [XLEN-1:0]   rfRdData,
  input  logic [XLEN-1:0]   memRspData,
  input  lsuStrobeT         strobe,
  output logic              legal,
  output logic [REG_AW-1:0] rfRdAddr,
  output logic [XLEN-1:0]   memReqAddr,
  output logic [1:0]        memReqSize,
  output logic [REG_AW-1:0] rfWrAddr,
  output logic [XLEN-1:0]   rfWrData
);
  localparam int LANES = XLEN / 8;
  localparam int OFF_W = 16;

  logic [7:0]        opByte;
  logic [2:0]        clsF, modeF;
  logic [1:0]        sizeF;
  logic [OFF_W-1:0]  dispF;
  logic [XLEN-1:0]   dispExt;

  assign opByte  = instLow[7:0];
  assign clsF    = opByte[2:0];
  assign sizeF   = opByte[4:3];
  assign modeF   = opByte[7:5];
  assign rfRdAddr = instLow[8+REG_AW +: REG_AW];
  assign dispF   = instLow[16 +: OFF_W];
  assign dispExt = {{(XLEN-OFF_W){dispF[OFF_W-1]}}, dispF};

  assign legal = (clsF == CLS_LOAD) &&
                 ((modeF == MODE_ZEXT) || ((modeF == MODE_SEXT) && (sizeF != SZ_DWORD)));

  logic [XLEN-1:0]   addrQ;
  logic [REG_AW-1:0] dstQ;
  logic [1:0]        sizeQ;
  logic              sextQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ <= '0;
      dstQ  <= '0;
      sizeQ <= '0;
      sextQ <= 1'b0;
    end else if (strobe.capture) begin
      addrQ <= rfRdData + dispExt;
      dstQ  <= instLow[8 +: REG_AW];
      sizeQ <= sizeF;
      sextQ <= (modeF == MODE_SEXT);
    end
  end

  assign memReqAddr = addrQ;
  assign memReqSize = sizeQ;
  assign rfWrAddr   = dstQ;

  logic [3:0] nBytes;
  logic       topBit;
  logic       fillBit;

  assign nBytes = sizeToBytes(sizeQ);

  always_comb begin
    case (sizeQ)
      2'd0: topBit = memRspData[31];
      2'd1: topBit = memRspData[15];
      2'd2: topBit = memRspData[7];
      default: topBit = memRspData[XLEN-1];
    endcase
  end

  assign fillBit = sextQ & topBit;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign rfWrData[8*k +: 8] = (k < int'(nBytes)) ? memRspData[8*k +: 8] : {8{fillBit}};
  end
endmodule

// File: rtl/load_sext_unit.sv
module load_sext_unit
  import lsu_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        instValid,
  input  logic [63:0] instWord,
  output logic        instReady,
  output logic        illegalInst,
  output logic [3:0]  rfRdAddr,
  input  logic [63:0] rfRdData,
  output logic        memReqValid,
  input  logic        memReqReady,
  output logic [63:0] memReqAddr,
  output logic [1:0]  memReqSize,
  input  logic        memRspValid,
  input  logic [63:0] memRspData,
  output logic        rfWrEn,
  output logic [3:0]  rfWrAddr,
  output logic [63:0] rfWrData
);
  lsuStrobeT strobe;
  logic      legal;
  logic      unusedImm;

  assign unusedImm = ^instWord[63:32];

  lsu_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .instValid(instValid), .legal(legal),
    .memReqReady(memReqReady), .memRspValid(memRspValid),
    .instReady(instReady), .memReqValid(memReqValid),
    .illegalInst(illegalInst), .strobe(strobe)
  );

  lsu_dpath #(.XLEN(64), .REG_AW(4)) u_dpath (
    .clk(clk), .rstN(rstN), .instLow(instWord[31:0]), .rfRdData(rfRdData),
    .memRspData(memRspData), .strobe(strobe), .legal(legal),
    .rfRdAddr(rfRdAddr), .memReqAddr(memReqAddr), .memReqSize(memReqSize),
    .rfWrAddr(rfWrAddr), .rfWrData(rfWrData)
  );

  assign rfWrEn = strobe.writeBack;
endmodule

// File: rtl/load_sext_unit_chk.sv
module load_sext_unit_chk (
  input logic        clk,
  input logic        rstN,
  input logic        instReady,
  input logic        illegalInst,
  input logic        memReqValid,
  input logic        memReqReady,
  input logic [63:0] memReqAddr,
  input logic        memRspValid,
  input logic        rfWrEn
);
  // R3
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid && !memReqReady |=> memReqValid && $stable(memReqAddr));

  // R7
  wr_needs_rsp_chk: assert property (@(posedge clk) disable iff (!rstN)
    rfWrEn |-> memRspValid);

  // R7
  wr_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    rfWrEn |=> !rfWrEn);

  // R8
  illegal_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    illegalInst |-> !memReqValid && !rfWrEn);

  // R10
  busy_no_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |-> !instReady);
endmodule

bind load_sext_unit load_sext_unit_chk u_chk (.*);

// File: tb/load_sext_unit_bench.sv
module load_sext_unit_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        instValid = 1'b0;
  logic [63:0] instWord = '0;
  logic        instReady, illegalInst, memReqValid, rfWrEn;
  logic [3:0]  rfRdAddr, rfWrAddr;
  logic [63:0] rfRdData, memReqAddr, rfWrData;
  logic [1:0]  memReqSize;
  logic        memReqReady = 1'b0;
  logic        memRspValid = 1'b0;
  logic [63:0] memRspData = '0;
  logic [63:0] regs [16];
  int checks = 0;
  int fails = 0;

  always #10 clk = ~clk;

  assign rfRdData = regs[rfRdAddr];

  load_sext_unit u_load_sext_unit (.*);

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] mkInst(input logic [7:0] op, input logic [3:0] d,
                                         input logic [3:0] s, input logic [15:0] off);
    return {32'h0BAD_F00D, off, s, d, op};
  endfunction

  task automatic runLoad(input logic [7:0] op, input logic [3:0] d, input logic [3:0] s,
                         input logic [15:0] off, input logic [63:0] rsp, input int reqWait,
                         input int rspWait, input logic [63:0] expData, input string tag);
    logic [63:0] expAddr;
    expAddr = regs[s] + {{48{off[15]}}, off};
    @(negedge clk);
    instWord = mkInst(op, d, s, off);
    instValid = 1'b1;
    #1;
    chk(instReady == 1'b1, {tag, " R10 ready"}, 64'(instReady), 64'd1);
    chk(rfRdAddr == s, {tag, " R2 src"}, 64'(rfRdAddr), 64'(s));
    @(negedge clk);
    instValid = 1'b0;
    #1;
    chk(memReqValid == 1'b1, {tag, " R3 valid"}, 64'(memReqValid), 64'd1);
    chk(memReqAddr == expAddr, {tag, " R3 addr"}, memReqAddr, expAddr);
    chk(memReqSize == op[4:3], {tag, " R4 size"}, 64'(memReqSize), 64'(op[4:3]));
    for (int i = 0; i < reqWait; i++) begin
      @(negedge clk);
      #1;
      chk(memReqValid && memReqAddr == expAddr, {tag, " R3 hold"}, memReqAddr, expAddr);
    end
    memReqReady = 1'b1;
    if (rspWait == 0) begin
      memRspValid = 1'b1;
      memRspData = rsp;
      #1;
      chk(rfWrEn == 1'b1, {tag, " R9 same-cycle write"}, 64'(rfWrEn), 64'd1);
      chk(rfWrData == expData, {tag, " R5/R6 data"}, rfWrData, expData);
      chk(rfWrAddr == d, {tag, " R7 dst"}, 64'(rfWrAddr), 64'(d));
      @(negedge clk);
      memReqReady = 1'b0;
      memRspValid = 1'b0;
    end else begin
      #1;
      chk(rfWrEn == 1'b0, {tag, " R7 no early write"}, 64'(rfWrEn), 64'd0);
      @(negedge clk);
      memReqReady = 1'b0;
      for (int i = 1; i < rspWait; i++) begin
        #1;
        chk(rfWrEn == 1'b0 && memReqValid == 1'b0, {tag, " R7 wait"}, 64'(rfWrEn), 64'd0);
        @(negedge clk);
      end
      memRspValid = 1'b1;
      memRspData = rsp;
      #1;
      chk(rfWrEn == 1'b1, {tag, " R7 write"}, 64'(rfWrEn), 64'd1);
      chk(rfWrData == expData, {tag, " R5/R6 data"}, rfWrData, expData);
      chk(rfWrAddr == d, {tag, " R7 dst"}, 64'(rfWrAddr), 64'(d));
      @(negedge clk);
      memRspValid = 1'b0;
    end
    #1;
    chk(instReady == 1'b1 && rfWrEn == 1'b0, {tag, " R7 single write"}, 64'(rfWrEn), 64'd0);
  endtask

  task automatic runIllegal(input logic [7:0] op, input string tag);
    @(negedge clk);
    instWord = mkInst(op, 4'd2, 4'd3, 16'h0004);
    instValid = 1'b1;
    @(negedge clk);
    instValid = 1'b0;
    #1;
    chk(illegalInst == 1'b1, {tag, " R8 flag"}, 64'(illegalInst), 64'd1);
    chk(memReqValid == 1'b0 && rfWrEn == 1'b0, {tag, " R8 no access"}, 64'(memReqValid), 64'd0);
    @(negedge clk);
    #1;
    chk(illegalInst == 1'b0 && memReqValid == 1'b0, {tag, " R8 pulse"}, 64'(illegalInst), 64'd0);
  endtask

  task automatic testReset();
    #1;
    chk(instReady == 1'b1, "R1 instReady", 64'(instReady), 64'd1);
    chk(memReqValid == 1'b0, "R1 memReqValid", 64'(memReqValid), 64'd0);
    chk(rfWrEn == 1'b0, "R1 rfWrEn", 64'(rfWrEn), 64'd0);
    chk(illegalInst == 1'b0, "R1 illegalInst", 64'(illegalInst), 64'd0);
  endtask

  task automatic testBusyIgnore();
    int writes = 0;
    int flags = 0;
    @(negedge clk);
    instWord = mkInst(8'h71, 4'd5, 4'd3, 16'h0000);
    instValid = 1'b1;
    @(negedge clk);
    instWord = mkInst(8'h99, 4'd6, 4'd3, 16'h0000);
    for (int i = 0; i < 3; i++) begin
      #1;
      chk(instReady == 1'b0, "R10 busy ready", 64'(instReady), 64'd0);
      @(negedge clk);
    end
    memReqReady = 1'b1;
    @(negedge clk);
    memReqReady = 1'b0;
    memRspValid = 1'b1;
    memRspData = 64'h0000_0000_0000_00C3;
    #1;
    chk(rfWrEn && rfWrAddr == 4'd5 && rfWrData == 64'hC3, "R10 busy result", rfWrData, 64'hC3);
    instValid = 1'b0;
    @(negedge clk);
    memRspValid = 1'b0;
    for (int i = 0; i < 3; i++) begin
      #1;
      if (rfWrEn) writes++;
      if (illegalInst) flags++;
      @(negedge clk);
    end
    chk(writes == 0 && flags == 0, "R10 ignored word", 64'(writes + flags), 64'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog R1 actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) regs[i] = 64'h0000_0100_0000_0000 + 64'(i * 64'h1000);
    regs[10] = 64'h0000_0000_0000_1000;
    regs[3]  = 64'h0000_0000_0000_2000;
    regs[0]  = 64'h0;
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    testReset();
    // R6 signed byte, negative displacement
    runLoad(8'h91, 4'd1, 4'd10, 16'hFFFF, 64'h1122_3344_5566_7780, 0, 0, 64'hFFFF_FFFF_FFFF_FF80, "sx8");
    // R5 zero-extended byte
    runLoad(8'h71, 4'd2, 4'd3, 16'h0010, 64'h1122_3344_5566_7780, 1, 2, 64'h80, "zx8");
    // R6 signed half negative / positive
    runLoad(8'h89, 4'd4, 4'd3, 16'h0002, 64'h1234_5678_1234_8001, 2, 1, 64'hFFFF_FFFF_FFFF_8001, "sx16n");
    runLoad(8'h89, 4'd4, 4'd3, 16'h0002, 64'hFFFF_FFFF_FFFF_7001, 0, 3, 64'h7001, "sx16p");
    // R6 signed word / R5 zero word
    runLoad(8'h81, 4'd7, 4'd10, 16'h8000, 64'hAAAA_BBBB_8000_0000, 0, 1, 64'hFFFF_FFFF_8000_0000, "sx32");
    runLoad(8'h61, 4'd8, 4'd10, 16'h7FFF, 64'hAAAA_BBBB_8000_0000, 1, 0, 64'h8000_0000, "zx32");
    // R5 double word, R3 address wrap below zero
    runLoad(8'h79, 4'd15, 4'd0, 16'hFFF8, 64'hDEAD_BEEF_CAFE_F00D, 0, 0, 64'hDEAD_BEEF_CAFE_F00D, "zx64");
    // R8 illegal encodings
    runIllegal(8'h99, "sx64");
    runIllegal(8'h41, "mode2");
    runIllegal(8'h72, "class2");
    testBusyIgnore();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule